// File: doc/BRIEF.md
# Power-Mode-Aware Watchdog Timer

This block is a watchdog built from a free-running base counter and a programmable postscaler. Each cycle in which the tick enable is high advances the base counter. Each wrap of the base counter advances the postscaler. A time-out happens when the base counter wraps while the postscaler sits at its terminal value. The total period is 2^BASE_W × 2^N enabled ticks, where N is the postscale select.

What a time-out does depends on the reported power mode. If the core is executing code (run mode), the block issues a one-cycle reset pulse. If the core is not executing (idle or sleep), it issues a one-cycle wake pulse instead. Both counters clear on any of four events:
- a sleep-instruction strobe;
- a clear-watchdog strobe;
- a clock-loss indication, but only while the fail-safe monitor is enabled;
- a change of the internal-oscillator frequency select, but only while the internal oscillator drives the device clock.

A small state machine sequences the output. It has three states:
- `ST_COUNT`: counting;
- `ST_WAKE`: wake pulse;
- `ST_RESET`: reset pulse.

It has four transitions:
- `ST_COUNT` to `ST_WAKE`, on a time-out in a non-run mode;
- `ST_COUNT` to `ST_RESET`, on a time-out in run mode;
- `ST_WAKE` to `ST_COUNT`, unconditionally after one cycle;
- `ST_RESET` to `ST_COUNT`, unconditionally after one cycle.

`ST_COUNT` stays in `ST_COUNT` whenever there is no time-out, or when a time-out coincides with a clear.

Top module: `mode_wdt`

## Requirements
- R1: A time-out occurs on the 2^BASE_W × 2^N-th cycle with `tick_en` high, counted since the last clear or time-out, where N = `ps_sel` (0 to 15). Cycles with `tick_en` low do not advance the count.
- R2: A time-out while `pwr_mode` is 2'b01 (idle), 2'b10 (sleep) or 2'b11 (treated as idle) raises `wake_pulse` for exactly one cycle, in the cycle after the time-out tick. `rst_pulse` stays low.
- R3: A time-out while `pwr_mode` is 2'b00 (run) raises `rst_pulse` for exactly one cycle, in the cycle after the time-out tick. `wake_pulse` stays low.
- R4: A cycle with `sleep_stb` high clears both the base counter and the postscaler.
- R5: A cycle with `clrwdt_stb` high clears both the base counter and the postscaler.
- R6: `clk_lost` clears both counters only when `fscm_en` is high. With `fscm_en` low it has no effect.
- R7: `osc_sel_chg` clears both counters only when `intosc_sel` is high. With `intosc_sel` low it has no effect.
- R8: After a time-out the count restarts from zero, so the next time-out needs a full period of enabled ticks.
- R9: When a clear event and a time-out fall in the same cycle, the clear wins. No pulse is issued and the count restarts from zero.
- R10: While `rst_n` is low and after its release, both outputs are low and the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the watchdog by one tick this cycle |
| ps_sel | input | SEL_W (4) | Postscale select N, ratio 2^N |
| pwr_mode | input | 2 | 00 run, 01 idle, 10 sleep, 11 idle |
| sleep_stb | input | 1 | Sleep instruction executed |
| clrwdt_stb | input | 1 | Clear-watchdog instruction executed |
| clk_lost | input | 1 | Selected clock source lost |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| osc_sel_chg | input | 1 | Internal-oscillator frequency select changed |
| intosc_sel | input | 1 | Internal oscillator is the device clock |
| wake_pulse | output | 1 | One-cycle wake on time-out outside run mode |
| rst_pulse | output | 1 | One-cycle reset on time-out in run mode |

## Verification
The time-out path is driven with these patterns:
- A continuous tick stream at postscale 0 and 1. This separates a correct period from one that is off by a single tick.
- A gated, alternating tick stream. This tells apart counting of enabled ticks from counting of cycles.
- Runs in each of the run, idle and sleep encodings. These show that the time-out is routed to the wake or the reset output by mode.

Each clear source is applied mid-period, with its qualifying enable both high and low. A full period is then counted, so an ignored clear shows up as an early pulse. A clear placed exactly on the terminal tick confirms that the clear suppresses the pulse.

// File: rtl/mwdt_pkg.sv
package mwdt_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10,
        PM_IDLE2 = 2'b11
    } pwr_mode_t;

    typedef enum logic [1:0] {
        ST_COUNT = 2'b00,
        ST_WAKE  = 2'b01,
        ST_RESET = 2'b10
    } wdt_state_t;

endpackage

// File: rtl/mwdt_clear.sv
module mwdt_clear (
    input  logic sleep_stb,
    input  logic clrwdt_stb,
    input  logic clk_lost,
    input  logic fscm_en,
    input  logic osc_sel_chg,
    input  logic intosc_sel,
    output logic clr_o
);

    logic lost_q;
    logic osc_q;

    always_comb begin
        lost_q = clk_lost & fscm_en;
        osc_q  = osc_sel_chg & intosc_sel;
        clr_o  = sleep_stb | clrwdt_stb | lost_q | osc_q;
    end

endmodule

// File: rtl/mwdt_counter.sv
module mwdt_counter #(
    parameter int BASE_W = 4,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clr,
    input  logic [SEL_W-1:0] ps_sel,
    output logic             timeout_o
);

    localparam int PS_W = (1 << SEL_W) - 1;

    logic [BASE_W-1:0] base_q;
    logic [PS_W-1:0]   ps_q;
    logic [PS_W-1:0]   ps_limit;
    logic              base_wrap;

    always_comb begin
        ps_limit  = PS_W'((PS_W+1)'(1) << ps_sel) - PS_W'(1);
        base_wrap = tick_en && (base_q == {BASE_W{1'b1}});
        timeout_o = base_wrap && (ps_q >= ps_limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr || timeout_o) begin
            base_q <= '0;
            ps_q   <= '0;
        end else if (tick_en) begin
            base_q <= base_q + BASE_W'(1);
            if (base_wrap) begin
                ps_q <= ps_q + PS_W'(1);
            end
        end
    end

endmodule

// File: rtl/mwdt_fsm.sv
module mwdt_fsm
    import mwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timeout,
    input  logic       clr,
    input  logic [1:0] pwr_mode,
    output logic       wake_o,
    output logic       rst_o
);

    wdt_state_t state_q;
    wdt_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (timeout && !clr) begin
                    if (pwr_mode == PM_RUN) begin
                        state_d = ST_RESET;
                    end else begin
                        state_d = ST_WAKE;
                    end
                end
            end
            ST_WAKE:  state_d = ST_COUNT;
            ST_RESET: state_d = ST_COUNT;
            default:  state_d = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        wake_o = 1'b0;
        rst_o  = 1'b0;
        unique case (state_q)
            ST_COUNT: ;
            ST_WAKE:  wake_o = 1'b1;
            ST_RESET: rst_o  = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/mode_wdt.sv
module mode_wdt #(
    parameter int BASE_W = 4,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] ps_sel,
    input  logic [1:0]       pwr_mode,
    input  logic             sleep_stb,
    input  logic             clrwdt_stb,
    input  logic             clk_lost,
    input  logic             fscm_en,
    input  logic             osc_sel_chg,
    input  logic             intosc_sel,
    output logic             wake_pulse,
    output logic             rst_pulse
);

    logic clr;
    logic timeout;

    mwdt_clear u_clear (
        .sleep_stb  (sleep_stb),
        .clrwdt_stb (clrwdt_stb),
        .clk_lost   (clk_lost),
        .fscm_en    (fscm_en),
        .osc_sel_chg(osc_sel_chg),
        .intosc_sel (intosc_sel),
        .clr_o      (clr)
    );

    mwdt_counter #(
        .BASE_W(BASE_W),
        .SEL_W (SEL_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .clr      (clr),
        .ps_sel   (ps_sel),
        .timeout_o(timeout)
    );

    mwdt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .timeout (timeout),
        .clr     (clr),
        .pwr_mode(pwr_mode),
        .wake_o  (wake_pulse),
        .rst_o   (rst_pulse)
    );

endmodule

// File: rtl/mode_wdt_chk.sv
module mode_wdt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic [1:0] pwr_mode,
    input logic       sleep_stb,
    input logic       clrwdt_stb,
    input logic       clk_lost,
    input logic       fscm_en,
    input logic       osc_sel_chg,
    input logic       intosc_sel,
    input logic       timeout,
    input logic       wake_pulse,
    input logic       rst_pulse
);

    logic any_clear;
    assign any_clear = sleep_stb | clrwdt_stb | (clk_lost & fscm_en)
                     | (osc_sel_chg & intosc_sel);

    a_r2_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    a_r3_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    a_r2_wake_not_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse) |-> $past(pwr_mode) != 2'b00);

    a_r3_reset_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> $past(pwr_mode) == 2'b00);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_clear |=> !wake_pulse && !rst_pulse);

    a_r1_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse || rst_pulse) |-> $past(tick_en) && $past(timeout));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_pulse && rst_pulse));

endmodule

bind mode_wdt mode_wdt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .pwr_mode   (pwr_mode),
    .sleep_stb  (sleep_stb),
    .clrwdt_stb (clrwdt_stb),
    .clk_lost   (clk_lost),
    .fscm_en    (fscm_en),
    .osc_sel_chg(osc_sel_chg),
    .intosc_sel (intosc_sel),
    .timeout    (timeout),
    .wake_pulse (wake_pulse),
    .rst_pulse  (rst_pulse)
);

// File: tb/mode_wdt_tb.sv
`timescale 1ns/1ps
module mode_wdt_tb;

    localparam int BASE_W = 4;
    localparam int SEL_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic [SEL_W-1:0] ps_sel = '0;
    logic [1:0]       pwr_mode = 2'b00;
    logic             sleep_stb = 1'b0;
    logic             clrwdt_stb = 1'b0;
    logic             clk_lost = 1'b0;
    logic             fscm_en = 1'b0;
    logic             osc_sel_chg = 1'b0;
    logic             intosc_sel = 1'b0;
    logic             wake_pulse;
    logic             rst_pulse;

    int n_checks = 0;
    int n_err    = 0;
    int wake_cnt = 0;
    int rst_cnt  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    mode_wdt #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ps_sel(ps_sel),
        .pwr_mode(pwr_mode), .sleep_stb(sleep_stb), .clrwdt_stb(clrwdt_stb),
        .clk_lost(clk_lost), .fscm_en(fscm_en), .osc_sel_chg(osc_sel_chg),
        .intosc_sel(intosc_sel), .wake_pulse(wake_pulse), .rst_pulse(rst_pulse)
    );

    // behavioural reference: total enabled ticks since last restart
    int  m_ticks = 0;
    bit  exp_wake = 0;
    bit  exp_rst  = 0;

    always @(posedge clk) begin
        int period;
        bit clr;
        period = (1 << BASE_W) * (1 << ps_sel);
        clr = sleep_stb || clrwdt_stb || (clk_lost && fscm_en)
              || (osc_sel_chg && intosc_sel);
        exp_wake = 0;
        exp_rst  = 0;
        if (!rst_n || clr) begin
            m_ticks = 0;
        end else if (tick_en) begin
            if (m_ticks + 1 >= period) begin
                m_ticks = 0;
                if (pwr_mode == 2'b00) exp_rst = 1;
                else exp_wake = 1;
            end else begin
                m_ticks = m_ticks + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (wake_pulse !== exp_wake) begin
                n_err++;
                $display("FAIL R2 wake_pulse act=%0b exp=%0b t=%0t", wake_pulse, exp_wake, $time);
            end
            n_checks++;
            if (rst_pulse !== exp_rst) begin
                n_err++;
                $display("FAIL R3 rst_pulse act=%0b exp=%0b t=%0t", rst_pulse, exp_rst, $time);
            end
            if (wake_pulse === 1'b1) wake_cnt++;
            if (rst_pulse === 1'b1) rst_cnt++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        tick_en = 1'b0;
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic restart();
        @(negedge clk);
        clrwdt_stb = 1'b1;
        @(negedge clk);
        clrwdt_stb = 1'b0;
        wake_cnt = 0;
        rst_cnt  = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10 wake in reset", wake_cnt, 0);
        check("R10 reset in reset", rst_cnt, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: sleep, N=0, period 16
        pwr_mode = 2'b10; ps_sel = 4'd0;
        ticks(15); settle();
        check("R1 no wake after 15 ticks", wake_cnt, 0);
        check("R10 count started at zero", rst_cnt, 0);
        ticks(1); settle();
        check("R2 wake after 16 ticks", wake_cnt, 1);
        check("R2 no reset in sleep", rst_cnt, 0);
        // R8 restart from zero
        ticks(15); settle();
        check("R8 no early second wake", wake_cnt, 1);
        ticks(1); settle();
        check("R8 second wake after full period", wake_cnt, 2);

        // R3: run, N=1, period 32
        restart(); pwr_mode = 2'b00; ps_sel = 4'd1;
        ticks(31); settle();
        check("R1 no reset after 31 ticks", rst_cnt, 0);
        ticks(1); settle();
        check("R3 reset after 32 ticks", rst_cnt, 1);
        check("R3 no wake in run", wake_cnt, 0);

        // R1 gated ticks, idle mode
        restart(); pwr_mode = 2'b01; ps_sel = 4'd0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            tick_en = (i % 2 == 0);
        end
        settle();
        check("R1 gated ticks wake in idle", wake_cnt, 1);

        // R5 clear-watchdog mid period
        restart(); pwr_mode = 2'b10;
        ticks(10); restart();
        ticks(10); settle();
        check("R5 clrwdt cleared count", wake_cnt, 0);
        ticks(6); settle();
        check("R5 wake after full period", wake_cnt, 1);

        // R4 sleep strobe
        restart(); ticks(10);
        @(negedge clk); sleep_stb = 1'b1; @(negedge clk); sleep_stb = 1'b0;
        ticks(10); settle();
        check("R4 sleep strobe cleared count", wake_cnt, 0);

        // R6 clock loss, gated by monitor enable
        restart(); ticks(10);
        @(negedge clk); clk_lost = 1'b1; fscm_en = 1'b0;
        @(negedge clk); clk_lost = 1'b0;
        ticks(6); settle();
        check("R6 clock loss ignored when monitor off", wake_cnt, 1);
        restart(); ticks(10);
        @(negedge clk); clk_lost = 1'b1; fscm_en = 1'b1;
        @(negedge clk); clk_lost = 1'b0; fscm_en = 1'b0;
        ticks(10); settle();
        check("R6 clock loss clears when monitor on", wake_cnt, 0);

        // R7 oscillator select change, gated by internal osc
        restart(); ticks(10);
        @(negedge clk); osc_sel_chg = 1'b1; intosc_sel = 1'b0;
        @(negedge clk); osc_sel_chg = 1'b0;
        ticks(6); settle();
        check("R7 select change ignored off internal osc", wake_cnt, 1);
        restart(); ticks(10);
        @(negedge clk); osc_sel_chg = 1'b1; intosc_sel = 1'b1;
        @(negedge clk); osc_sel_chg = 1'b0; intosc_sel = 1'b0;
        ticks(10); settle();
        check("R7 select change clears on internal osc", wake_cnt, 0);

        // R9 clear on the terminal tick, run mode
        restart(); pwr_mode = 2'b00;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk); tick_en = 1'b1;
        end
        @(negedge clk); tick_en = 1'b1; clrwdt_stb = 1'b1;
        @(negedge clk); tick_en = 1'b0; clrwdt_stb = 1'b0;
        settle();
        check("R9 clear beats time-out", rst_cnt, 0);
        ticks(16); settle();
        check("R9 restart from zero after clear", rst_cnt, 1);

        // mode 11 acts as idle
        restart(); pwr_mode = 2'b11;
        ticks(16); settle();
        check("R2 mode 11 wakes", wake_cnt, 1);
        check("R2 mode 11 no reset", rst_cnt, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_err++;
            $display("FAIL R1 watchdog expired act=1 exp=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule